// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a free-running watchdog counter that advances on a low-speed timebase tick (nominally 32.768 kHz, given to the block as a one-cycle enable). Software chooses one of four timeout lengths and must clear the counter with a kick strobe before the chosen period elapses. No software control can stop the counter. It only restarts on a kick or on the block's own synchronous reset.

Failure to kick escalates in two steps. The first timeout since the last clear sends a single-cycle non-maskable interrupt request and records that an interrupt is outstanding. If the next timeout arrives while that record is still set, the block raises a system reset request. The request stays high until the block itself is reset. A kick removes the outstanding record, so a serviced interrupt starts the escalation over. The period selection is sampled only at reset and at a kick. A change on the select input therefore waits for the next clear.

Top module: `wdog_escalator`

## Requirements
- R1: While `rst` is high, both `nmi_pulse` and `reset_req` are low in the cycle after each reset edge. The counter restarts from zero, and the period selection is sampled at every reset edge.
- R2: `period_sel` value s gives a timeout of 2^(BASE_LOG2 + STEP_LOG2*s) ticks. With the defaults, 0, 1, 2 and 3 select 4096, 16384, 65536 and 262144 ticks. `nmi_pulse` is high in the cycle after the clock edge that carries the last tick of the period counted from the clear.
- R3: The counter advances only on clock edges where `tick` is high. With `tick` low its value is held.
- R4: The first timeout after a clear drives `nmi_pulse` high for exactly one cycle.
- R5: A timeout that arrives while the interrupt from the previous timeout is still outstanding sets `reset_req`. `reset_req` then stays high until `rst`, and a kick does not clear it.
- R6: A kick zeroes the counter and clears the outstanding-interrupt record, so the next timeout sends a fresh `nmi_pulse` instead of a reset request.
- R7: A change on `period_sel` does not alter the running period. The new value is taken at the next kick or reset.
- R8: A kick on the same edge as the period's last tick wins. No `nmi_pulse` follows, and the counter restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Low-speed timebase enable, one cycle per count |
| period_sel | input | SEL_W | Timeout length select, sampled at kick or reset |
| kick | input | 1 | Clear strobe from software |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request |
| reset_req | output | 1 | Sticky system reset request |

## Verification
The in-module assertions cover the rules that hold on every cycle: the interrupt is one cycle wide, the reset request is sticky, the count holds without a tick, the count stays within the selected terminal value, the latched selection is stable between clears, and a kick suppresses the interrupt on the next cycle. Only the bench's scenarios can show the absolute period for each select value and the order of escalation from interrupt to reset request. They also show that a kick restarts escalation while leaving a raised request in place, that a select change waits for the next kick, and that a kick on the terminal tick wins.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // Number of ticks in the period chosen by select value idx.
   function automatic logic [63:0] period_ticks(input int base_log2,
                                                input int step_log2,
                                                input int idx);
      return 64'd1 << (base_log2 + step_log2 * idx);
   endfunction

   // Counter width needed to hold the longest terminal count.
   function automatic int cnt_width(input int base_log2,
                                    input int step_log2,
                                    input int sel_w);
      return base_log2 + step_log2 * ((1 << sel_w) - 1);
   endfunction

   typedef enum logic [1:0] {
      ESC_IDLE    = 2'b00,
      ESC_PENDING = 2'b01,
      ESC_TRIPPED = 2'b11
   } esc_state_e;

endpackage

// File: rtl/wdog_period_sel.sv
module wdog_period_sel #(
   parameter int SEL_W     = 2,
   parameter int BASE_LOG2 = 12,
   parameter int STEP_LOG2 = 2,
   parameter int CNT_W     = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             kick,
   input  logic [SEL_W-1:0] sel_in,
   output logic [CNT_W-1:0] term_now,
   output logic [CNT_W-1:0] term_next
);

   localparam int NUM_PERIODS = 1 << SEL_W;

   logic [CNT_W-1:0] lut [NUM_PERIODS];
   logic [SEL_W-1:0] sel_q;
   logic [SEL_W-1:0] sel_nxt;
   logic             load;

   for (genvar i = 0; i < NUM_PERIODS; i++) begin : g_lut
      assign lut[i] = CNT_W'(wdog_pkg::period_ticks(BASE_LOG2, STEP_LOG2, i) - 64'd1);
   end

   assign load    = rst | kick;
   assign sel_nxt = load ? sel_in : sel_q;

   always_ff @(posedge clk) begin
      if (load) sel_q <= sel_in;
   end

   assign term_now  = lut[sel_q];
   assign term_next = lut[sel_nxt];

   AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
      !kick |=> (sel_q == $past(sel_q)));  // R7

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W      = 18,
   parameter bit DOWN_COUNT = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             kick,
   input  logic [CNT_W-1:0] term_now,
   input  logic [CNT_W-1:0] term_next,
   output logic             wrap
);

   logic [CNT_W-1:0] cnt;
   logic             restart;
   logic             at_end;

   assign restart = rst | kick;

   if (DOWN_COUNT) begin : g_down
      // Loads the terminal value and counts toward zero.
      assign at_end = (cnt == '0);

      always_ff @(posedge clk) begin
         if (restart)   cnt <= term_next;
         else if (tick) cnt <= at_end ? term_now : cnt - 1'b1;
      end

      AST_DOWN_RESTART: assert property (@(posedge clk) disable iff (rst)
         kick |=> (cnt == term_now));  // R6
   end else begin : g_up
      // Counts from zero up to the terminal value.
      logic unused_next;
      assign unused_next = ^term_next;
      assign at_end      = (cnt == term_now);

      always_ff @(posedge clk) begin
         if (restart)   cnt <= '0;
         else if (tick) cnt <= at_end ? '0 : cnt + 1'b1;
      end

      AST_UP_RESTART: assert property (@(posedge clk) disable iff (rst)
         kick |=> (cnt == '0));  // R6
   end

   assign wrap = tick & at_end & ~restart;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt <= term_now);  // R2

   AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (rst)
      (!tick && !kick) |=> $stable(cnt));  // R3

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate (
   input  logic clk,
   input  logic rst,
   input  logic kick,
   input  logic wrap,
   output logic nmi_o,
   output logic req_o
);

   import wdog_pkg::*;

   esc_state_e state_q;
   logic       nmi_q;
   logic       req_q;
   logic       pend;

   assign pend = (state_q != ESC_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ESC_IDLE;
         nmi_q   <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         nmi_q <= wrap & ~pend;
         if (wrap & pend) req_q <= 1'b1;
         if (kick)
            state_q <= ESC_IDLE;
         else if (wrap)
            state_q <= pend ? ESC_TRIPPED : ESC_PENDING;
      end
   end

   assign nmi_o = nmi_q;
   assign req_o = req_q;

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!nmi_q && !req_q));  // R1

   AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (rst)
      nmi_q |=> !nmi_q);  // R4

   AST_REQ_STICKY: assert property (@(posedge clk) disable iff (rst)
      req_q |=> req_q);  // R5

endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator #(
   parameter int BASE_LOG2  = 12,
   parameter int STEP_LOG2  = 2,
   parameter int SEL_W      = 2,
   parameter bit DOWN_COUNT = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic [SEL_W-1:0] period_sel,
   input  logic             kick,
   output logic             nmi_pulse,
   output logic             reset_req
);

   localparam int CNT_W = wdog_pkg::cnt_width(BASE_LOG2, STEP_LOG2, SEL_W);

   if (BASE_LOG2 < 2) begin : g_bad_base
      $error("wdog_escalator: BASE_LOG2 must be at least 2");
   end
   if (STEP_LOG2 < 1) begin : g_bad_step
      $error("wdog_escalator: STEP_LOG2 must be at least 1");
   end
   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("wdog_escalator: SEL_W must lie in 1..3");
   end
   if (CNT_W > 40) begin : g_bad_width
      $error("wdog_escalator: longest period exceeds 40 counter bits");
   end

   logic [CNT_W-1:0] term_now;
   logic [CNT_W-1:0] term_next;
   logic             wrap;

   wdog_period_sel #(
      .SEL_W     (SEL_W),
      .BASE_LOG2 (BASE_LOG2),
      .STEP_LOG2 (STEP_LOG2),
      .CNT_W     (CNT_W)
   ) period_i (
      .clk       (clk),
      .rst       (rst),
      .kick      (kick),
      .sel_in    (period_sel),
      .term_now  (term_now),
      .term_next (term_next)
   );

   wdog_counter #(
      .CNT_W      (CNT_W),
      .DOWN_COUNT (DOWN_COUNT)
   ) counter_i (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .kick      (kick),
      .term_now  (term_now),
      .term_next (term_next),
      .wrap      (wrap)
   );

   wdog_escalate escalate_i (
      .clk   (clk),
      .rst   (rst),
      .kick  (kick),
      .wrap  (wrap),
      .nmi_o (nmi_pulse),
      .req_o (reset_req)
   );

   AST_KICK_NO_NMI: assert property (@(posedge clk) disable iff (rst)
      kick |=> !nmi_pulse);  // R8

endmodule

// File: tb/wdog_escalator_tb_top.sv
module wdog_escalator_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int BASE = 4;
   localparam int STEP = 2;
   localparam int L0 = 16, L1 = 64, L2 = 256, L3 = 1024;

   localparam int EV_NMI = 0, EV_REQ_ON = 1, EV_REQ_OFF = 2;

   typedef struct {
      int    cyc;
      int    kind;
      string tag;
   } ev_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b1;
   logic [1:0] period_sel = 2'd0;
   logic       kick = 1'b0;
   logic       nmi_pulse;
   logic       reset_req;

   int    cyc = 0;
   int    errors = 0;
   int    checks = 0;
   bit    mon_on = 1'b0;
   bit    done = 1'b0;
   bit    exp_nmi;
   bit    exp_req = 1'b0;
   string cur_tag = "R1";
   string tag;
   ev_t   ev;
   ev_t   q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdog_escalator #(
      .BASE_LOG2  (BASE),
      .STEP_LOG2  (STEP),
      .SEL_W      (2),
      .DOWN_COUNT (1'b0)
   ) dut_i (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .period_sel (period_sel),
      .kick       (kick),
      .nmi_pulse  (nmi_pulse),
      .reset_req  (reset_req)
   );

   // Driver side: expected events enter the scoreboard in cycle order.
   task automatic push(input int c, input int kind, input string t);
      ev_t e;
      int  i;
      e.cyc = c; e.kind = kind; e.tag = t;
      i = q.size();
      while (i > 0 && q[i-1].cyc > c) i--;
      q.insert(i, e);
   endtask

   task automatic wait_to(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic do_kick(output int edge_c);
      @(negedge clk);
      kick = 1'b1;
      edge_c = cyc + 1;
      @(negedge clk);
      kick = 1'b0;
   endtask

   task automatic do_reset(output int base_c);
      @(negedge clk);
      rst = 1'b1;
      push(cyc + 1, EV_REQ_OFF, "R1");
      repeat (2) @(negedge clk);
      rst = 1'b0;
      base_c = cyc;
   endtask

   // Monitor side: pops due events and compares both outputs each cycle.
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (mon_on && !done) begin
         exp_nmi = 1'b0;
         tag = cur_tag;
         while (q.size() > 0 && q[0].cyc <= cyc) begin
            ev = q.pop_front();
            if (ev.cyc < cyc) begin
               errors++; checks++;
               $display("FAIL %s stale event cyc=%0d actual=%0d expected=%0d", ev.tag, cyc, cyc, ev.cyc);
            end
            case (ev.kind)
               EV_NMI:    exp_nmi = 1'b1;
               EV_REQ_ON: exp_req = 1'b1;
               default:   exp_req = 1'b0;
            endcase
            tag = ev.tag;
         end
         checks++;
         if (nmi_pulse !== exp_nmi) begin
            errors++;
            $display("FAIL %s nmi_pulse cyc=%0d actual=%0b expected=%0b", tag, cyc, nmi_pulse, exp_nmi);
         end
         checks++;
         if (reset_req !== exp_req) begin
            errors++;
            $display("FAIL %s reset_req cyc=%0d actual=%0b expected=%0b", tag, cyc, reset_req, exp_req);
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired at cyc=%0d actual=running expected=finished", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int b, k, k2, k3, k4, k5, k6, k7, k8, k9;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      b = cyc;
      mon_on = 1'b1;

      // R1 reset state, R4 first timeout, R5 escalation at the second one.
      cur_tag = "R1";
      push(b + L0, EV_NMI, "R4");
      push(b + 2*L0, EV_REQ_ON, "R5");
      wait_to(b + 2*L0 + 8);

      // R5: a kick leaves the request high; R6: pending cleared, fresh NMI.
      cur_tag = "R5";
      do_kick(k);
      push(k + L0, EV_NMI, "R6");
      wait_to(k + 2*L0 + 8);

      // R1: reset clears the request and samples select 1.
      period_sel = 2'd1;
      do_reset(b);
      cur_tag = "R6";
      wait_to(b + 40);
      do_kick(k);
      push(k + L1, EV_NMI, "R2");
      wait_to(k + L1 + 6);
      do_kick(k2);
      push(k2 + L1, EV_NMI, "R6");
      wait_to(k2 + L1 + 6);

      // R7: select change without a kick keeps the running period.
      do_kick(k3);
      period_sel = 2'd0;
      cur_tag = "R7";
      push(k3 + L1, EV_NMI, "R7");
      wait_to(k3 + L1 + 6);
      do_kick(k4);
      push(k4 + L0, EV_NMI, "R7");
      wait_to(k4 + L0 + 4);

      // R8: kick on the edge of the second timeout wins.
      cur_tag = "R8";
      wait_to(k4 + 2*L0 - 2);
      do_kick(k5);
      push(k5 + L0, EV_NMI, "R8");
      wait_to(k5 + L0 + 4);

      // R3: ticks on alternate edges double the elapsed cycles.
      cur_tag = "R3";
      do_kick(k6);
      tick = 1'b1;
      push(k6 + 2*L0 - 1, EV_NMI, "R3");
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         tick = i[0];
      end
      do_kick(k7);
      tick = 1'b0;
      push(k7 + 100 + L0, EV_NMI, "R3");
      repeat (100) @(negedge clk);
      tick = 1'b1;
      wait_to(k7 + 100 + L0 + 4);

      // R2: the two longer periods, then R5 on the longest.
      cur_tag = "R2";
      period_sel = 2'd2;
      do_kick(k8);
      push(k8 + L2, EV_NMI, "R2");
      wait_to(k8 + L2 + 4);
      period_sel = 2'd3;
      do_kick(k9);
      push(k9 + L3, EV_NMI, "R2");
      push(k9 + 2*L3, EV_REQ_ON, "R5");
      wait_to(k9 + 2*L3 + 12);

      cur_tag = "R1";
      do_reset(b);
      wait_to(b + 20);

      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R2 unconsumed events actual=%0d expected=0", q.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule